// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM whose read and write operations share one data-bus slot timing, so a read can follow a write, or a write a read, on consecutive edges with no idle cycle. A command is captured on a rising edge. Read data reaches the output one enabled edge later. Write data is taken two enabled edges later. The array is small. Its depth is set by a parameter. A word is 36 bits, split into four 9-bit byte lanes.

A started operation can run as a four-beat burst. The sequencer counts the low two address bits in linear or in XOR (interleaved) order, and the count wraps back to the starting address. The clock enable suspends the whole pipeline. The chip select ends a burst. The sleep input freezes the block after a two-cycle delay and releases it after a two-cycle wake-up. Writes still in flight survive deselect and suspension. A read of an address whose write is still pending returns the newer data.

Top module: `zt_pipe_sram`

## Requirements
- R1: After reset, dout_en is low, dout is zero and no operation is pending.
- R2: An edge with cke_n low, adv low and cs_n low starts an operation at addr. It is a write if we_n is low and a read if we_n is high.
- R3: Read data for a command captured at enabled edge N is on dout after enabled edge N+1 and stays there for the whole cycle. dout_en is high for that slot only while oe_n is low, and oe_n acts without a clock edge.
- R4: Write data is taken from din at enabled edge N+2. bw_n is sampled with the command. bw_n[k] low writes lane k, which is bits 9k+8 down to 9k.
- R5: A write with all four bw_n bits high leaves the array unchanged.
- R6: Reads and writes may follow each other on every edge. A read of an address whose write is still in the pipeline returns that write's data.
- R7: adv high at an enabled edge continues the active burst. The upper address bits are held. Beat i has low bits start+i mod 4 when il_order is 0, and start XOR i when il_order is 1. The fifth beat returns to the start address.
- R8: adv low with cs_n high deselects the block and ends the burst. adv high while deselected keeps it deselected. Deselected slots and write slots drive dout_en low.
- R9: With cke_n high, every synchronous input is ignored and all state, dout included, holds. A pending write takes its data at its second enabled edge, however many suspended cycles come between.
- R10: If sleep is high before edge k, edges k and k+1 still run. Later edges are ignored and dout_en is low while the sleep takes effect. If sleep is lowered before edge m, edges m and m+1 are still ignored and edge m+2 runs. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke_n | input | 1 | Active-low clock enable; high suspends the block |
| cs_n | input | 1 | Active-low chip select |
| adv | input | 1 | Low loads a new command; high continues the burst |
| we_n | input | 1 | Active-low write select for a loaded command |
| bw_n | input | 4 | Active-low per-lane write enables |
| addr | input | 4 | Word address |
| oe_n | input | 1 | Active-low output enable, asynchronous |
| il_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request, active high |
| din | input | 36 | Write data bus |
| dout | output | 36 | Read data bus |
| dout_en | output | 1 | High when dout is driven |

## Verification
A table-driven stream interleaves single writes, reads and deselects with no gaps. Several reads hit an address written just before them. This separates correct late-write timing from an array read that misses the write still in flight, and it also checks that deselected and write slots leave the bus undriven. Burst reads from the same start address in both orders, plus a fifth beat, tell the linear sequence apart from the XOR sequence and show that the count wraps. Directed tests then stretch writes and reads across clock-enable suspension and across the sleep window. A write that wakes one edge too early would corrupt a later read, so the exact two-cycle entry and exit timing is checked.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
   // Width of the burst beat index; a burst is 2**BEAT_W beats long.
   localparam int BEAT_W = 2;

   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } burst_order_e;
endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
   import zt_sram_pkg::*;
#(
   parameter bit HAS_IL = 1'b1
) (
   input  logic [BEAT_W-1:0] start_lo,
   input  logic [BEAT_W-1:0] idx,
   input  logic              il,
   output logic [BEAT_W-1:0] lo
);
   generate
      if (HAS_IL) begin : g_both
         assign lo = (burst_order_e'(il) == ORD_XOR) ? (start_lo ^ idx)
                                                     : BEAT_W'(start_lo + idx);
      end else begin : g_lin
         logic unused_il;
         assign unused_il = il;
         assign lo = BEAT_W'(start_lo + idx);
      end
   endgenerate
endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
   parameter int AW     = 4,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [LANES-1:0]        wr_lane,
   input  logic [AW-1:0]           wr_addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [AW-1:0]           rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_lane[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end

      assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];

      // R5
      lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_lane[g]) |=> mem[$past(rd_addr)] === $past(rd_data[g*LANE_W +: LANE_W]));
   end
endmodule

// File: rtl/zt_pipe_sram.sv
module zt_pipe_sram
   import zt_sram_pkg::*;
#(
   parameter int AW     = 4,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter bit HAS_IL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke_n,
   input  logic                    cs_n,
   input  logic                    adv,
   input  logic                    we_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic [AW-1:0]           addr,
   input  logic                    oe_n,
   input  logic                    il_order,
   input  logic                    sleep,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_en
);
   localparam int DW = LANES * LANE_W;

   generate
      if (AW <= BEAT_W) begin : g_bad_aw
         initial $fatal(1, "AW must exceed the burst index width");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         initial $fatal(1, "lane count and lane width must be positive");
      end
   endgenerate

   typedef struct packed {
      logic             vld;
      logic             wr;
      logic [AW-1:0]    a;
      logic [LANES-1:0] bwn;
   } slot_t;

   slot_t             s1_q, s2_q, s1_d;
   logic [1:0]        slp_q;
   logic              run, load, desel, cont;
   logic              brst_act_q, brst_wr_q;
   logic [AW-1:0]     base_q, cur_a;
   logic [BEAT_W-1:0] cnt_q, seq_lo;
   logic [DW-1:0]     arr_rd, byp_rd, dout_q;
   logic              rd_vld_q, wr_fire;

   // Sleep request delay line: two edges to take effect, two to release.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slp_q <= '0;
      else        slp_q <= {slp_q[0], sleep};
   end

   assign run   = !cke_n && !slp_q[1];
   assign load  = !adv && !cs_n;
   assign desel = !adv && cs_n;
   assign cont  = adv && brst_act_q;

   zt_burst_seq #(.HAS_IL(HAS_IL)) u_seq (
      .start_lo(base_q[BEAT_W-1:0]),
      .idx     (cnt_q),
      .il      (il_order),
      .lo      (seq_lo)
   );

   assign cur_a = load ? addr : {base_q[AW-1:BEAT_W], seq_lo};

   always_comb begin
      s1_d.vld = load || cont;
      s1_d.wr  = load ? !we_n : brst_wr_q;
      s1_d.a   = cur_a;
      s1_d.bwn = bw_n;
   end

   // Burst state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brst_act_q <= 1'b0;
         brst_wr_q  <= 1'b0;
         base_q     <= '0;
         cnt_q      <= '0;
      end else if (run) begin
         if (load) begin
            brst_act_q <= 1'b1;
            brst_wr_q  <= !we_n;
            base_q     <= addr;
            cnt_q      <= BEAT_W'(1);
         end else if (desel) begin
            brst_act_q <= 1'b0;
         end else if (cont) begin
            cnt_q <= BEAT_W'(cnt_q + 1'b1);
         end
      end
   end

   // Two-stage command pipeline and output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q     <= '0;
         s2_q     <= '0;
         rd_vld_q <= 1'b0;
         dout_q   <= '0;
      end else if (run) begin
         s1_q     <= s1_d;
         s2_q     <= s1_q;
         rd_vld_q <= s1_q.vld && !s1_q.wr;
         if (s1_q.vld && !s1_q.wr) dout_q <= byp_rd;
      end
   end

   assign wr_fire = run && s2_q.vld && s2_q.wr;

   zt_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_fire),
      .wr_lane(~s2_q.bwn),
      .wr_addr(s2_q.a),
      .wr_data(din),
      .rd_addr(s1_q.a),
      .rd_data(arr_rd)
   );

   // Bypass: the write committing on this edge overrides the array per lane
   for (genvar g = 0; g < LANES; g++) begin : g_byp
      assign byp_rd[g*LANE_W +: LANE_W] =
         (s2_q.vld && s2_q.wr && !s2_q.bwn[g] && (s2_q.a == s1_q.a))
            ? din[g*LANE_W +: LANE_W] : arr_rd[g*LANE_W +: LANE_W];
   end

   assign dout    = dout_q;
   assign dout_en = rd_vld_q && !oe_n && !slp_q[1];

   // R7
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cont) |=> cnt_q == BEAT_W'($past(cnt_q) + 1'b1));

   // R8
   desel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && desel) |=> (!s1_q.vld && !brst_act_q));

   // R3
   read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && s1_q.vld && !s1_q.wr) |=> rd_vld_q);

   // R9
   suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> ($stable(dout_q) && $stable(s2_q) && $stable(cnt_q)));

   // R10
   sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slp_q[1] |=> ($stable(s1_q) && $stable(dout_q)));
endmodule

// File: tb/zt_pipe_sram_bench.sv
module zt_pipe_sram_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cke_n, cs_n, adv, we_n, oe_n, il_order, sleep;
   logic [3:0]  bw_n, addr;
   logic [35:0] din, dout;
   logic        dout_en;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   zt_pipe_sram u_zt_pipe_sram (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_n(cs_n), .adv(adv),
      .we_n(we_n), .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .il_order(il_order),
      .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
   );

   // Entry: {kind[1:0], addr[3:0], data[35:0]}; kind 0 deselect, 1 read (data = expected), 2 write
   localparam int NV = 13;
   localparam logic [41:0] VEC [NV] = '{
      {2'd2, 4'h3, 36'h1_1111_1111},
      {2'd2, 4'h5, 36'h2_2222_2222},
      {2'd1, 4'h3, 36'h1_1111_1111},
      {2'd2, 4'h3, 36'h3_3333_3333},
      {2'd1, 4'h3, 36'h3_3333_3333},
      {2'd1, 4'h5, 36'h2_2222_2222},
      {2'd2, 4'h7, 36'h4_4444_4444},
      {2'd0, 4'h0, 36'h0},
      {2'd1, 4'h7, 36'h4_4444_4444},
      {2'd2, 4'h3, 36'hA_5A5A_5A5A},
      {2'd1, 4'h3, 36'hA_5A5A_5A5A},
      {2'd0, 4'h0, 36'h0},
      {2'd0, 4'h0, 36'h0}
   };

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cmd(input logic [1:0] kind, input logic [3:0] a);
      cke_n = 1'b0;
      addr  = a;
      case (kind)
         2'd0:    begin adv = 1'b0; cs_n = 1'b1; we_n = 1'b1; end
         2'd1:    begin adv = 1'b0; cs_n = 1'b0; we_n = 1'b1; end
         default: begin adv = 1'b0; cs_n = 1'b0; we_n = 1'b0; end
      endcase
   endtask

   task automatic burst_next();
      cke_n = 1'b0;
      adv   = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cke_n = 1'b0; cs_n = 1'b1; adv = 1'b0; we_n = 1'b1;
      bw_n = 4'hF; addr = '0; oe_n = 1'b0; il_order = 1'b0; sleep = 1'b0; din = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 dout_en", {35'd0, dout_en}, 36'd0);
      chk("R1 dout", dout, 36'd0);

      // Table stream: back-to-back reads and writes (R2 R6), idle slots (R8)
      bw_n = 4'h0;
      for (int i = 0; i <= NV; i++) begin
         logic [41:0] cv;
         logic [41:0] pv;
         cv = (i < NV) ? VEC[i] : 42'd0;
         cmd(cv[41:40], cv[39:36]);
         din = '0;
         if (i >= 2) begin
            if (VEC[i-2][41:40] == 2'd2) din = VEC[i-2][35:0];
         end
         tick();
         if (i >= 1) begin
            pv = VEC[i-1];
            if (pv[41:40] == 2'd1) begin
               chk("R2 R6 read valid", {35'd0, dout_en}, 36'd1);
               chk("R6 read data", dout, pv[35:0]);
            end else begin
               chk("R8 idle slot", {35'd0, dout_en}, 36'd0);
            end
         end
      end

      // R7 linear burst write from 5: beats land on 5,6,7,4
      il_order = 1'b0; bw_n = 4'h0;
      cmd(2'd2, 4'h5); din = '0; tick();
      burst_next(); tick();
      burst_next(); din = 36'hB_0000_0000; tick();
      burst_next(); din = 36'hB_0000_0001; tick();
      cmd(2'd0, 4'h0); din = 36'hB_0000_0002; tick();
      cmd(2'd0, 4'h0); din = 36'hB_0000_0003; tick();

      // R7 interleaved burst read from 7: 7,6,5,4 then wrap to 7
      il_order = 1'b1;
      cmd(2'd1, 4'h7); tick();
      burst_next(); tick(); chk("R7 xor beat0", dout, 36'hB_0000_0002);
      burst_next(); tick(); chk("R7 xor beat1", dout, 36'hB_0000_0001);
      burst_next(); tick(); chk("R7 xor beat2", dout, 36'hB_0000_0000);
      burst_next(); tick(); chk("R7 xor beat3", dout, 36'hB_0000_0003);
      cmd(2'd0, 4'h0); tick(); chk("R7 wrap beat", dout, 36'hB_0000_0002);
      burst_next(); tick(); chk("R8 deselect slot", {35'd0, dout_en}, 36'd0);
      tick(); chk("R8 continued deselect", {35'd0, dout_en}, 36'd0);

      // R7 linear burst read from 7: 7,4,5,6
      il_order = 1'b0;
      cmd(2'd1, 4'h7); tick();
      burst_next(); tick(); chk("R7 lin beat0", dout, 36'hB_0000_0002);
      burst_next(); tick(); chk("R7 lin beat1", dout, 36'hB_0000_0003);
      burst_next(); tick(); chk("R7 lin beat2", dout, 36'hB_0000_0000);
      cmd(2'd0, 4'h0); tick(); chk("R7 lin beat3", dout, 36'hB_0000_0001);

      // R4 byte lanes, R5 abort: three writes to 9
      cmd(2'd2, 4'h9); bw_n = 4'h0; tick();
      cmd(2'd2, 4'h9); bw_n = 4'b1010; tick();
      cmd(2'd2, 4'h9); bw_n = 4'b1111; din = 36'h0; tick();
      cmd(2'd0, 4'h0); bw_n = 4'h0; din = 36'hF_FFFF_FFFF; tick();
      cmd(2'd0, 4'h0); din = 36'h0; tick();
      cmd(2'd1, 4'h9); tick();
      cmd(2'd0, 4'h0); tick();
      chk("R4 R5 lanes 0 and 2 only", dout, 36'h0_07FC_01FF);
      tick();

      // R9 suspended read: deselect requests while suspended are ignored
      cmd(2'd1, 4'h5); tick();
      for (int k = 0; k < 3; k++) begin
         cmd(2'd0, 4'h0); cke_n = 1'b1; tick();
         chk("R9 suspended no output", {35'd0, dout_en}, 36'd0);
      end
      cmd(2'd0, 4'h0); tick();
      chk("R9 read after suspend valid", {35'd0, dout_en}, 36'd1);
      chk("R9 read after suspend data", dout, 36'hB_0000_0000);

      // R9 suspended write takes data at its second enabled edge
      cmd(2'd2, 4'hB); tick();
      cmd(2'd0, 4'h0); cke_n = 1'b1; din = 36'hD_EAD0_0000; tick(); tick();
      cmd(2'd0, 4'h0); din = 36'hD_EAD0_0001; tick();
      cmd(2'd0, 4'h0); din = 36'h5_0505_0505; tick();
      din = '0;
      cmd(2'd1, 4'hB); tick();
      cmd(2'd0, 4'h0); tick();
      chk("R9 suspended write data", dout, 36'h5_0505_0505);

      // R10 sleep: write 12, then sleep window
      cmd(2'd2, 4'hC); tick();
      cmd(2'd0, 4'h0); tick();
      cmd(2'd0, 4'h0); din = 36'h6_1234_5678; tick();
      din = '0;
      sleep = 1'b1;
      cmd(2'd0, 4'h0); tick();
      cmd(2'd0, 4'h0); tick();
      cmd(2'd2, 4'hC); tick();
      chk("R10 asleep no output", {35'd0, dout_en}, 36'd0);
      tick();
      sleep = 1'b0;
      tick(); tick();
      cmd(2'd1, 4'hC); tick();
      cmd(2'd0, 4'h0); din = '0; tick();
      chk("R10 wake read valid", {35'd0, dout_en}, 36'd1);
      chk("R10 contents kept", dout, 36'h6_1234_5678);

      // R3 output enable acts without a clock edge
      oe_n = 1'b1; #1;
      chk("R3 oe high releases bus", {35'd0, dout_en}, 36'd0);
      oe_n = 1'b0; #1;
      chk("R3 oe low drives bus", {35'd0, dout_en}, 36'd1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule